// File: doc/BRIEF.md
# Product-Term Macrocell Function Block

This block is a configurable sum-of-products logic array. A bus of literals, made from the external inputs and from the registered output of every macrocell, feeds an AND plane. Each product term has its own mask, and each term is set per mask bit to use the true or the complemented form of any signal. A steering stage sends every term to the OR gate of its own macrocell, lends it to the next macrocell, or drops it. Each macrocell then passes its sum through a storage element. That element can act as a D flip-flop or a T flip-flop, or it can be bypassed. The result drives a pin model that reports a data value and a drive enable.

A single serial shift chain holds the whole configuration. The chain loads only while the global set/reset is held high. The global set/reset acts asynchronously: each macrocell's register is cleared or preset, as a per-macrocell bit chooses. A global output enable gates the pins that are configured as tri-state or open-drain. While the chain is being loaded, every pin is released. The number of inputs, the number of macrocells and the number of product terms per macrocell are parameters.

Top module: `fb_product_term_block`

## Requirements
- R1: The configuration chain shifts one bit per rising clock edge, but only while `cfg_en` and `gsr` are both high. Shifting enters at bit 0 and moves toward the top bit, so the first bit sent lands in the top bit. When `cfg_en` is high and `gsr` is low, the chain does not shift. Each macrocell m owns a record of MC_W = PT*(2*NSIG+2)+5 bits, which starts at bit m*MC_W (NSIG = NUM_IN+NUM_MC). Inside the record, term t starts at t*(2*NSIG+2) and holds its literal mask, followed by a 2-bit route. After the last term come the mode (2 bits), the reset value (1 bit) and the pin kind (2 bits).
- R2: Every bit of `pin_oe` is 0 while `cfg_en` is high.
- R3: A product term is the AND of the literals enabled in its mask. Mask bit 2k selects signal k and bit 2k+1 selects its complement. Signals 0..NUM_IN-1 are the `in_bus` bits, and signal NUM_IN+j is the register of macrocell j. A term with an empty mask is 0.
- R4: Route code 1 adds the term to the macrocell's own sum. Route code 2 adds it to the sum of macrocell (m+1) mod NUM_MC. Codes 0 and 3 drop the term.
- R5: Mode 1 registers the sum as a D flip-flop, and mode 2 toggles the register on each clock edge where the sum is 1. Modes 0 and 3 bypass the register: the pin value follows the sum with no clock delay.
- R6: While `gsr` is high, each register takes the value of its reset bit (1 = preset, 0 = clear), without waiting for a clock edge.
- R7: Feedback into the AND plane always comes from the register. In bypass mode the register still captures the sum on every edge, so the feedback lags the pin by one cycle.
- R8: Pin kind 0 (push-pull) always drives. Kind 1 (tri-state) drives when `goe` is high. Kind 2 (open-drain) drives a 0 only when `goe` is high and the value is 0. Kind 3 never drives.
- R9: When `goe` is low, pins of kind 1 and 2 are released, and pins of kind 0 keep driving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock |
| gsr | input | 1 | Global set/reset, asynchronous, active high |
| goe | input | 1 | Global output enable |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data |
| in_bus | input | NUM_IN | External inputs to the AND plane |
| pin_o | output | NUM_MC | Value driven on each pin |
| pin_oe | output | NUM_MC | Drive enable of each pin |

## Verification
The register checks assume that the configuration does not change while `gsr` is low. They also assume that `gsr` is not pulsed between two clock edges within a single cycle. The D and T properties are therefore disabled while `gsr` is high. The stimulus follows these rules: it loads each configuration with `gsr` held high, and it changes data inputs and enables only in the middle of the low clock phase. The one stray shift attempt is made with `gsr` low. This shows at the pins that the loaded function stays the same.

// File: rtl/fb_pkg.sv
package fb_pkg;
    typedef enum logic [1:0] {
        MC_BYPASS     = 2'd0,
        MC_DFF        = 2'd1,
        MC_TFF        = 2'd2,
        MC_BYPASS_ALT = 2'd3
    } mc_mode_e;

    typedef enum logic [1:0] {
        PIN_PUSH = 2'd0,
        PIN_TRI  = 2'd1,
        PIN_OD   = 2'd2,
        PIN_OFF  = 2'd3
    } pin_kind_e;

    typedef enum logic [1:0] {
        RT_DROP     = 2'd0,
        RT_OWN      = 2'd1,
        RT_NEXT     = 2'd2,
        RT_DROP_ALT = 2'd3
    } route_e;
endpackage

// File: rtl/fb_cfg_chain.sv
module fb_cfg_chain #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] cfg
);
    logic [W-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (shift_en) cfg_d = {cfg_q[W-2:0], din};
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/fb_and_plane.sv
module fb_and_plane #(
    parameter int NSIG  = 8,
    parameter int NTERM = 16
) (
    input  logic [NSIG-1:0]         sig,
    input  logic [NTERM*2*NSIG-1:0] mask,
    output logic [NTERM-1:0]        term
);
    localparam int LIT = 2 * NSIG;

    logic [LIT-1:0] lit;

    for (genvar k = 0; k < NSIG; k++) begin : g_lit
        assign lit[2*k]   = sig[k];
        assign lit[2*k+1] = ~sig[k];
    end

    for (genvar t = 0; t < NTERM; t++) begin : g_term
        logic [LIT-1:0] m;
        assign m       = mask[t*LIT +: LIT];
        assign term[t] = (|m) & (&(lit | ~m));
    end
endmodule

// File: rtl/fb_allocator.sv
module fb_allocator
    import fb_pkg::*;
#(
    parameter int NUM_MC = 4,
    parameter int PT     = 4
) (
    input  logic [NUM_MC*PT-1:0]   term,
    input  logic [NUM_MC*PT*2-1:0] route,
    output logic [NUM_MC-1:0]      sums
);
    always_comb begin
        sums = '0;
        for (int m = 0; m < NUM_MC; m++) begin
            for (int t = 0; t < PT; t++) begin
                case (route_e'(route[(m*PT+t)*2 +: 2]))
                    RT_OWN:  sums[m] = sums[m] | term[m*PT+t];
                    RT_NEXT: sums[(m+1)%NUM_MC] = sums[(m+1)%NUM_MC] | term[m*PT+t];
                    default: ;
                endcase
            end
        end
    end

    // R4: a sum can only be high if at least one product term is high
    always_comb begin
        p_sum_needs_term_r4: assert (!(|sums) || (|term))
            else $error("sum high with no product term high");
    end
endmodule

// File: rtl/fb_macrocell.sv
module fb_macrocell
    import fb_pkg::*;
(
    input  logic      clk,
    input  logic      gsr,
    input  logic      goe,
    input  logic      hold_hiz,
    input  logic      sum,
    input  mc_mode_e  mode,
    input  logic      rst_val,
    input  pin_kind_e kind,
    output logic      fb_q,
    output logic      pin_o,
    output logic      pin_oe
);
    typedef struct packed {
        logic q;
    } mc_state_t;

    mc_state_t st_d, st_q;
    logic      registered;
    logic      value;

    always_comb begin
        st_d = st_q;
        if (mode == MC_TFF) st_d.q = st_q.q ^ sum;
        else                st_d.q = sum;
    end

    always_ff @(posedge clk or posedge gsr) begin
        if (gsr) st_q.q <= rst_val;
        else     st_q   <= st_d;
    end

    assign registered = (mode == MC_DFF) || (mode == MC_TFF);
    assign value      = registered ? st_q.q : sum;
    assign fb_q       = st_q.q;

    always_comb begin
        pin_o  = value;
        pin_oe = 1'b0;
        case (kind)
            PIN_PUSH: pin_oe = 1'b1;
            PIN_TRI:  pin_oe = goe;
            PIN_OD: begin
                pin_o  = 1'b0;
                pin_oe = goe & ~value;
            end
            default:  pin_oe = 1'b0;
        endcase
        if (hold_hiz) pin_oe = 1'b0;
    end

    // R6: a register held in reset shows its reset value one edge later
    p_reset_value_r6: assert property (@(posedge clk)
        $past(gsr) |-> (fb_q == $past(rst_val)));

    // R5: D mode captures the sum
    p_dff_capture_r5: assert property (@(posedge clk) disable iff (gsr)
        (mode == MC_DFF) |=> (fb_q == $past(sum)));

    // R5: T mode toggles on a high sum
    p_tff_toggle_r5: assert property (@(posedge clk) disable iff (gsr)
        (mode == MC_TFF) |=> (fb_q == ($past(fb_q) ^ $past(sum))));

    // R9: gated pin kinds release when the global enable is low
    p_goe_release_r9: assert property (@(posedge clk) disable iff (gsr)
        (!goe && (kind == PIN_TRI || kind == PIN_OD)) |-> !pin_oe);
endmodule

// File: rtl/fb_product_term_block.sv
module fb_product_term_block
    import fb_pkg::*;
#(
    parameter int NUM_IN = 4,
    parameter int NUM_MC = 4,
    parameter int PT     = 4
) (
    input  logic              clk,
    input  logic              gsr,
    input  logic              goe,
    input  logic              cfg_en,
    input  logic              cfg_din,
    input  logic [NUM_IN-1:0] in_bus,
    output logic [NUM_MC-1:0] pin_o,
    output logic [NUM_MC-1:0] pin_oe
);
    localparam int NSIG   = NUM_IN + NUM_MC;
    localparam int LIT    = 2 * NSIG;
    localparam int TERM_W = LIT + 2;
    localparam int MC_W   = PT * TERM_W + 5;
    localparam int CFG_W  = NUM_MC * MC_W;
    localparam int NTERM  = NUM_MC * PT;

    logic [CFG_W-1:0]    cfg;
    logic [NTERM*LIT-1:0] masks;
    logic [NTERM*2-1:0]   routes;
    logic [NTERM-1:0]     terms;
    logic [NUM_MC-1:0]    sums;
    logic [NUM_MC-1:0]    fb_q;
    logic [NSIG-1:0]      sig;

    fb_cfg_chain #(.W(CFG_W)) u_chain (
        .clk      (clk),
        .shift_en (cfg_en & gsr),
        .din      (cfg_din),
        .cfg      (cfg)
    );

    assign sig = {fb_q, in_bus};

    for (genvar m = 0; m < NUM_MC; m++) begin : g_mc
        for (genvar t = 0; t < PT; t++) begin : g_t
            assign masks[(m*PT+t)*LIT +: LIT] = cfg[m*MC_W + t*TERM_W +: LIT];
            assign routes[(m*PT+t)*2 +: 2]    = cfg[m*MC_W + t*TERM_W + LIT +: 2];
        end

        mc_mode_e  mode;
        pin_kind_e kind;
        assign mode = mc_mode_e'(cfg[m*MC_W + PT*TERM_W +: 2]);
        assign kind = pin_kind_e'(cfg[m*MC_W + PT*TERM_W + 3 +: 2]);

        fb_macrocell u_mc (
            .clk      (clk),
            .gsr      (gsr),
            .goe      (goe),
            .hold_hiz (cfg_en),
            .sum      (sums[m]),
            .mode     (mode),
            .rst_val  (cfg[m*MC_W + PT*TERM_W + 2]),
            .kind     (kind),
            .fb_q     (fb_q[m]),
            .pin_o    (pin_o[m]),
            .pin_oe   (pin_oe[m])
        );
    end

    fb_and_plane #(.NSIG(NSIG), .NTERM(NTERM)) u_and (
        .sig  (sig),
        .mask (masks),
        .term (terms)
    );

    fb_allocator #(.NUM_MC(NUM_MC), .PT(PT)) u_alloc (
        .term  (terms),
        .route (routes),
        .sums  (sums)
    );

    // R2: no pin drives while the chain is loading
    p_hiz_while_loading_r2: assert property (@(posedge clk) disable iff (!gsr && !cfg_en)
        cfg_en |-> (pin_oe == '0));
endmodule

// File: tb/fb_product_term_block_test.sv
`timescale 1ns/100ps
module fb_product_term_block_test;
    localparam int NUM_IN = 4;
    localparam int NUM_MC = 4;
    localparam int PT     = 4;
    localparam int NSIG   = NUM_IN + NUM_MC;
    localparam int LIT    = 2 * NSIG;
    localparam int TERM_W = LIT + 2;
    localparam int MC_W   = PT * TERM_W + 5;
    localparam int CFG_W  = NUM_MC * MC_W;

    // {in_bus[3:0], expected pin0, expected pin1} for configuration A
    localparam logic [5:0] VEC [8] = '{
        6'b0000_10, 6'b0011_11, 6'b0100_00, 6'b0111_11,
        6'b1000_11, 6'b1101_01, 6'b0101_01, 6'b1111_11
    };

    logic clk = 1'b0;
    logic gsr = 1'b1;
    logic goe = 1'b1;
    logic cfg_en = 1'b0;
    logic cfg_din = 1'b0;
    logic [NUM_IN-1:0] in_bus = '0;
    logic [NUM_MC-1:0] pin_o, pin_oe;
    logic [CFG_W-1:0] img;
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    fb_product_term_block #(.NUM_IN(NUM_IN), .NUM_MC(NUM_MC), .PT(PT)) uut (
        .clk(clk), .gsr(gsr), .goe(goe), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .in_bus(in_bus), .pin_o(pin_o), .pin_oe(pin_oe)
    );

    always #2 clk = ~clk;

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic lit_on(int m, int t, int b);
        img[m*MC_W + t*TERM_W + b] = 1'b1;
    endtask

    task automatic set_route(int m, int t, logic [1:0] r);
        img[m*MC_W + t*TERM_W + LIT +: 2] = r;
    endtask

    task automatic set_mc(int m, logic [1:0] mode, logic rv, logic [1:0] kind);
        img[m*MC_W + PT*TERM_W +: 2]     = mode;
        img[m*MC_W + PT*TERM_W + 2]      = rv;
        img[m*MC_W + PT*TERM_W + 3 +: 2] = kind;
    endtask

    task automatic load();
        gsr = 1'b1;
        cfg_en = 1'b1;
        for (int i = CFG_W - 1; i >= 0; i--) begin
            tick();
            cfg_din = img[i];
            if (i == CFG_W / 2) chk("R2 pins released during load", {4'b0, pin_oe}, 8'h00);
        end
        tick();
        cfg_en = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // Configuration A: literal bit 2k = signal k true, 2k+1 = complement
        img = '0;
        lit_on(0, 0, 0); lit_on(0, 0, 2); set_route(0, 0, 2'd1);   // in0 & in1
        lit_on(0, 1, 5); set_route(0, 1, 2'd1);                    // ~in2
        lit_on(0, 2, 0); lit_on(0, 2, 7); set_route(0, 2, 2'd2);   // in0 & ~in3 lent to mc1
        set_mc(0, 2'd0, 1'b0, 2'd0);
        lit_on(1, 0, 6); set_route(1, 0, 2'd1);                    // in3
        set_mc(1, 2'd0, 1'b0, 2'd0);
        lit_on(2, 0, 2); set_route(2, 0, 2'd1);                    // in1, D
        set_mc(2, 2'd1, 1'b0, 2'd0);
        lit_on(3, 0, 4); set_route(3, 0, 2'd1);                    // in2, T
        set_mc(3, 2'd2, 1'b1, 2'd1);
        load();

        tick();
        chk("R6 clear value in reset", {7'b0, pin_o[2]}, 8'h01 & 8'h00);
        chk("R6 preset value in reset", {7'b0, pin_o[3]}, 8'h01);
        chk("R1 loaded tri pin drives", {7'b0, pin_oe[3]}, 8'h01);
        gsr = 1'b0;
        tick();
        chk("R5 T holds on zero sum", {7'b0, pin_o[3]}, 8'h01);
        in_bus = 4'b0100;
        tick();
        chk("R5 T toggles", {7'b0, pin_o[3]}, 8'h00);
        tick();
        chk("R5 T toggles again", {7'b0, pin_o[3]}, 8'h01);
        in_bus = 4'b0010;
        tick();
        chk("R5 D captures one", {7'b0, pin_o[2]}, 8'h01);
        chk("R5 T holds", {7'b0, pin_o[3]}, 8'h01);
        in_bus = 4'b0000;
        tick();
        chk("R5 D captures zero", {7'b0, pin_o[2]}, 8'h00);
        goe = 1'b0;
        #0.5;
        chk("R9 tri pin released", {7'b0, pin_oe[3]}, 8'h00);
        chk("R9 push pin still drives", {7'b0, pin_oe[2]}, 8'h01);
        goe = 1'b1;

        for (int v = 0; v < 8; v++) begin
            tick();
            in_bus = VEC[v][5:2];
            #0.5;
            chk("R3 R4 R5 bypass sum pin0", {7'b0, pin_o[0]}, {7'b0, VEC[v][1]});
            chk("R3 R4 R5 bypass sum and lend pin1", {7'b0, pin_o[1]}, {7'b0, VEC[v][0]});
        end

        tick();
        in_bus = 4'b0010;
        tick();
        tick();
        chk("R5 D set before async reset", {7'b0, pin_o[2]}, 8'h01);
        gsr = 1'b1;
        #0.5;
        chk("R6 asynchronous clear", {7'b0, pin_o[2]}, 8'h00);
        in_bus = '0;

        // Configuration B
        img = '0;
        lit_on(0, 0, 0); set_route(0, 0, 2'd1);                    // in0
        set_mc(0, 2'd0, 1'b0, 2'd2);                               // open-drain bypass
        lit_on(1, 0, 0); set_route(1, 0, 2'd1);
        set_mc(1, 2'd0, 1'b0, 2'd3);                               // never drives
        lit_on(2, 0, 8); set_route(2, 0, 2'd1);                    // register of mc0
        set_mc(2, 2'd1, 1'b0, 2'd0);
        set_route(3, 0, 2'd1);                                     // empty mask
        lit_on(3, 1, 6); set_route(3, 1, 2'd2);                    // in3 lent to mc0 (wrap)
        lit_on(3, 2, 0); set_route(3, 2, 2'd3);                    // dropped
        set_mc(3, 2'd1, 1'b1, 2'd0);
        load();

        tick();
        chk("R6 preset before release", {7'b0, pin_o[3]}, 8'h01);
        gsr = 1'b0;
        tick();
        chk("R3 R4 empty term and dropped route give zero", {7'b0, pin_o[3]}, 8'h00);
        chk("R8 open-drain pulls low", {6'b0, pin_oe[0], pin_o[0]}, 8'h02);
        in_bus = 4'b0001;
        #0.5;
        chk("R8 open-drain releases on one", {7'b0, pin_oe[0]}, 8'h00);
        chk("R8 kind 3 never drives", {7'b0, pin_oe[1]}, 8'h00);
        in_bus = 4'b1000;
        #0.5;
        chk("R4 lend wraps to mc0", {7'b0, pin_oe[0]}, 8'h00);
        in_bus = 4'b0000;
        goe = 1'b0;
        #0.5;
        chk("R9 open-drain released without goe", {7'b0, pin_oe[0]}, 8'h00);
        goe = 1'b1;
        tick();
        tick();
        chk("R7 feedback idle", {7'b0, pin_o[2]}, 8'h00);
        in_bus = 4'b0001;
        tick();
        chk("R7 feedback lags one cycle", {7'b0, pin_o[2]}, 8'h00);
        tick();
        chk("R7 feedback reaches D", {7'b0, pin_o[2]}, 8'h01);

        cfg_en = 1'b1;
        cfg_din = 1'b1;
        #0.5;
        chk("R2 pins released with cfg_en", {4'b0, pin_oe}, 8'h00);
        tick();
        tick();
        cfg_en = 1'b0;
        in_bus = 4'b0000;
        #0.5;
        chk("R1 no shift without gsr, open-drain low", {6'b0, pin_oe[0], pin_o[0]}, 8'h02);
        in_bus = 4'b0001;
        #0.5;
        chk("R1 no shift without gsr, open-drain off", {7'b0, pin_oe[0]}, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule